// File: doc/BRIEF.md
# Receiver Enable Delay Window Search

This block trains the read receiver-enable delay of eight DRAM byte lanes. After a start pulse it loads a starting delay for every lane and then runs a sweep of iterations. In each iteration it asks an external read agent for two test reads per rank. One read targets an address that holds the 0x55 pattern, and the other targets an address that holds the 0xAA pattern. The agent returns the first 64-bit data beat of each read. The block compares each lane's byte with the expected pattern and then moves that lane's delay by an amount that depends on the lane's pass/fail history.

Delays are counted in 1/32 UI steps. A failing lane moves forward by 1/8 UI. A passing lane moves by +1/32 UI and +1/4 UI in turn, so it covers the passing window with both fine and coarse steps. Once a lane has held a pass across 1.25 UI beyond the first passing delay, it is marked trained. Its delay is then set to 7/8 UI past that first passing delay and is not moved again. When the sweep ends, the block reports a fail flag for each lane, an overall error, and the largest final delay. It also raises a one-cycle done pulse.

The FSM states are IDLE, CHECK, ISSUE, EVAL and FINISH, with these transitions:

- IDLE to CHECK when start is seen. All lanes are loaded at this point.
- CHECK to FINISH when every lane is trained or the iteration limit has been reached.
- CHECK to ISSUE otherwise.
- ISSUE stays in ISSUE while rd_req is held and no response has arrived, and after any response that is not the last read of the iteration.
- ISSUE to EVAL on the last response of the iteration.
- EVAL to CHECK after the lanes are updated and the iteration count is incremented.
- FINISH to IDLE after the results are latched.

Top module: `rxen_window_search`

## Requirements
- R1: After reset, rd_req, done, lane_fail, err, max_dly and every lane of dly_out are 0. A start pulse seen in IDLE loads lane n of init_dly (bits 9n+8:9n) into lane n of dly_out on that same clock edge.
- R2: An iteration issues 2 reads when two_rank is 0 and 4 reads when it is 1, and rank 0's reads come before rank 1's. rd_sel 0 selects the 0x55 address and rd_sel 1 selects the 0xAA address. Iterations are counted from 0. In even iterations each rank reads rd_sel 0 then 1; in odd iterations the order is 1 then 0.
- R3: Lane n passes in an iteration when bits 8n+7:8n of the beat equal 0x55 for the rd_sel 0 read and 0xAA for the rd_sel 1 read. When two_rank is 1, the lane must pass on both ranks.
- R4: An untrained lane that fails advances its delay by 4. An untrained lane that passes advances by +1 and +8 in turn, and the first pass after a new candidate adds +1. All delay arithmetic is modulo 512.
- R5: A lane that passes when it did not pass in the previous iteration latches its current delay as its candidate. At the first iteration, the previous result counts as a fail.
- R6: A passing lane whose delay minus candidate is at least 0x28 becomes trained. Its delay is set to candidate + 0x1C and does not change until the next start.
- R7: The sweep stops once all lanes are trained, or after 128 iterations. done is then high for exactly one cycle, and the results are valid in that cycle.
- R8: On completion, lane_fail[n] is 1 exactly for the lanes that are still untrained, and err is the OR of lane_fail. max_dly is the largest final lane delay.
- R9: A start pulse that arrives while training is in progress has no effect.
- R10: rd_req stays high with stable rd_rank and rd_sel until a cycle in which rd_valid is high. The response is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training (synchronous, active high) |
| two_rank | input | 1 | Train against both ranks |
| init_dly | input | 72 | Starting delay per lane, 9 bits each |
| rd_req | output | 1 | Test read request |
| rd_rank | output | 1 | Rank of the requested read |
| rd_sel | output | 1 | 0: 0x55 address, 1: 0xAA address |
| rd_valid | input | 1 | Response valid for the pending request |
| rd_beat | input | 64 | First data beat of the read |
| dly_out | output | 72 | Current delay per lane, 9 bits each |
| done | output | 1 | One-cycle completion pulse |
| lane_fail | output | 8 | Lane not trained at completion |
| err | output | 1 | Any lane failed |
| max_dly | output | 9 | Largest final lane delay |

## Verification
The assertions assume that the read agent raises rd_valid only while rd_req is high, and that it keeps a beat only for the single cycle in which rd_valid is high. The bench's responder meets this by answering only a pending request, after a random wait of 0 to 2 cycles, and by dropping rd_valid on the next cycle. The responder builds each beat from the delay that dly_out presents for that lane at that moment, using a passing window for each lane and rank. A failing lane receives a byte that is guaranteed to differ from the expected pattern. Because of this, the only source of pass/fail outcomes is the windows the bench chose, and the bench's reference sweep can replay them exactly.

// File: rtl/rxen_pkg.sv
package rxen_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_EVAL,
        ST_FINISH
    } rxen_state_e;
endpackage

// File: rtl/rxen_beat_cmp.sv
module rxen_beat_cmp #(
    parameter int LANES  = 8,
    parameter logic [7:0] PAT_LO = 8'h55,
    parameter logic [7:0] PAT_HI = 8'hAA
) (
    input  logic [LANES*8-1:0] beat,
    input  logic               sel,
    output logic [LANES-1:0]   match
);
    logic [7:0] expect_byte;

    assign expect_byte = sel ? PAT_HI : PAT_LO;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign match[g] = (beat[g*8 +: 8] == expect_byte);
    end
endmodule

// File: rtl/rxen_lane.sv
module rxen_lane #(
    parameter int DLY_W     = 9,
    parameter int STEP_FAIL = 4,
    parameter int STEP_FINE = 1,
    parameter int STEP_WIDE = 8,
    parameter int SPAN      = 40,
    parameter int CENTER    = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] init,
    input  logic             upd,
    input  logic             pass,
    output logic [DLY_W-1:0] cur,
    output logic             trained
);
    localparam logic [DLY_W-1:0] INC_FAIL = DLY_W'(STEP_FAIL);
    localparam logic [DLY_W-1:0] INC_FINE = DLY_W'(STEP_FINE);
    localparam logic [DLY_W-1:0] INC_WIDE = DLY_W'(STEP_WIDE);
    localparam logic [DLY_W-1:0] LIM_SPAN = DLY_W'(SPAN);
    localparam logic [DLY_W-1:0] OFS_CTR  = DLY_W'(CENTER);

    logic [DLY_W-1:0] cand;
    logic             toggle;
    logic             prev_pass;
    logic             fresh;
    logic [DLY_W-1:0] cand_eff;
    logic             tog_eff;
    logic [DLY_W-1:0] span_now;

    // a pass after a fail opens a new window
    assign fresh    = pass & ~prev_pass;
    assign cand_eff = fresh ? cur : cand;
    assign tog_eff  = fresh ? 1'b0 : toggle;
    assign span_now = cur - cand_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= '0;
            cand      <= '0;
            toggle    <= 1'b0;
            prev_pass <= 1'b0;
            trained   <= 1'b0;
        end else if (load) begin
            cur       <= init;
            cand      <= init;
            toggle    <= 1'b0;
            prev_pass <= 1'b0;
            trained   <= 1'b0;
        end else if (upd && !trained) begin
            prev_pass <= pass;
            if (fresh) begin
                cand <= cur;
            end
            if (!pass) begin
                cur <= cur + INC_FAIL;
            end else if (span_now >= LIM_SPAN) begin
                trained <= 1'b1;
                cur     <= cand_eff + OFS_CTR;
            end else if (!tog_eff) begin
                cur    <= cur + INC_FINE;
                toggle <= 1'b1;
            end else begin
                cur    <= cur + INC_WIDE;
                toggle <= 1'b0;
            end
        end
    end

    AST_TRAINED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        trained && !load |=> $stable(cur)); // R6

    AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd && !load && !trained && !pass |=> (cur - $past(cur)) == INC_FAIL); // R4

    AST_TRAIN_SETS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        !load && $rose(trained) |-> (cur - cand) == OFS_CTR); // R6
endmodule

// File: rtl/rxen_seq.sv
module rxen_seq
    import rxen_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int MAX_ITER = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             two_rank,
    input  logic             rd_valid,
    input  logic [LANES-1:0] match,
    input  logic             all_trained,
    output logic             rd_req,
    output logic             rd_rank,
    output logic             rd_sel,
    output logic             load,
    output logic             upd,
    output logic [LANES-1:0] pass_vec,
    output logic             finish
);
    localparam int IT_W = $clog2(MAX_ITER + 1);
    localparam logic [IT_W-1:0] IT_LIMIT = IT_W'(MAX_ITER);

    rxen_state_e      state, state_nx;
    logic [IT_W-1:0]  iter_cnt;
    logic [1:0]       ridx;
    logic             two_q;
    logic [LANES-1:0] pass_acc;
    logic [1:0]       last_idx;

    assign last_idx = two_q ? 2'd3 : 2'd1;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = (all_trained || iter_cnt == IT_LIMIT) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (rd_valid && ridx == last_idx) state_nx = ST_EVAL;
            ST_EVAL:   state_nx = ST_CHECK;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_cnt <= '0;
            ridx     <= '0;
            two_q    <= 1'b0;
            pass_acc <= '1;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    iter_cnt <= '0;
                    ridx     <= '0;
                    two_q    <= two_rank;
                    pass_acc <= '1;
                end
                ST_ISSUE: if (rd_valid) begin
                    pass_acc <= pass_acc & match;
                    ridx     <= (ridx == last_idx) ? 2'd0 : ridx + 2'd1;
                end
                ST_EVAL: begin
                    iter_cnt <= iter_cnt + 1'b1;
                    pass_acc <= '1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_req   = (state == ST_ISSUE);
        rd_rank  = ridx[1];
        rd_sel   = ridx[0] ^ iter_cnt[0];
        load     = (state == ST_IDLE) && start;
        upd      = (state == ST_EVAL);
        finish   = (state == ST_FINISH);
        pass_vec = pass_acc;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_sel) && $stable(rd_rank)); // R10

    AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cnt <= IT_LIMIT); // R7

    AST_ONE_RANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !two_q |-> !rd_rank); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE && state != ST_FINISH |=> state != ST_IDLE); // R9
endmodule

// File: rtl/rxen_window_search.sv
module rxen_window_search #(
    parameter int LANES     = 8,
    parameter int DLY_W     = 9,
    parameter int MAX_ITER  = 128,
    parameter int STEP_FAIL = 4,
    parameter int STEP_FINE = 1,
    parameter int STEP_WIDE = 8,
    parameter int SPAN      = 40,
    parameter int CENTER    = 28,
    parameter logic [7:0] PAT_LO = 8'h55,
    parameter logic [7:0] PAT_HI = 8'hAA
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   two_rank,
    input  logic [LANES*DLY_W-1:0] init_dly,
    output logic                   rd_req,
    output logic                   rd_rank,
    output logic                   rd_sel,
    input  logic                   rd_valid,
    input  logic [LANES*8-1:0]     rd_beat,
    output logic [LANES*DLY_W-1:0] dly_out,
    output logic                   done,
    output logic [LANES-1:0]       lane_fail,
    output logic                   err,
    output logic [DLY_W-1:0]       max_dly
);
    logic [LANES-1:0] match;
    logic [LANES-1:0] pass_vec;
    logic [LANES-1:0] trained;
    logic             load;
    logic             upd;
    logic             finish;
    logic [DLY_W-1:0] max_now;

    rxen_seq #(.LANES(LANES), .MAX_ITER(MAX_ITER)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .two_rank(two_rank),
        .rd_valid(rd_valid), .match(match), .all_trained(&trained),
        .rd_req(rd_req), .rd_rank(rd_rank), .rd_sel(rd_sel),
        .load(load), .upd(upd), .pass_vec(pass_vec), .finish(finish)
    );

    rxen_beat_cmp #(.LANES(LANES), .PAT_LO(PAT_LO), .PAT_HI(PAT_HI)) u_cmp (
        .beat(rd_beat), .sel(rd_sel), .match(match)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxen_lane #(
            .DLY_W(DLY_W), .STEP_FAIL(STEP_FAIL), .STEP_FINE(STEP_FINE),
            .STEP_WIDE(STEP_WIDE), .SPAN(SPAN), .CENTER(CENTER)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .load(load),
            .init(init_dly[g*DLY_W +: DLY_W]), .upd(upd), .pass(pass_vec[g]),
            .cur(dly_out[g*DLY_W +: DLY_W]), .trained(trained[g])
        );
    end

    always_comb begin
        max_now = '0;
        for (int i = 0; i < LANES; i++) begin
            if (dly_out[i*DLY_W +: DLY_W] > max_now) max_now = dly_out[i*DLY_W +: DLY_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            lane_fail <= '0;
            err       <= 1'b0;
            max_dly   <= '0;
        end else if (load) begin
            done      <= 1'b0;
            lane_fail <= '0;
            err       <= 1'b0;
            max_dly   <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                lane_fail <= ~trained;
                err       <= ~&trained;
                max_dly   <= max_now;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (lane_fail != '0))); // R8

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req); // R7
endmodule

// File: tb/tb_rxen_window_search.sv
`timescale 1ns/1ps
module tb_rxen_window_search;
    localparam int L = 8;
    localparam int W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic two_rank = 1'b0;
    logic [L*W-1:0] init_dly = '0;
    logic rd_req, rd_rank, rd_sel;
    logic rd_valid = 1'b0;
    logic [L*8-1:0] rd_beat = '0;
    logic [L*W-1:0] dly_out;
    logic done;
    logic [L-1:0] lane_fail;
    logic err;
    logic [W-1:0] max_dly;

    int total = 0;
    int fails = 0;

    int lo0[L], hi0[L], lo1[L], hi1[L], ini[L];
    int exp_dly[L];
    bit exp_tr[L];
    int exp_it;

    always #2 clk = ~clk;

    rxen_window_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .two_rank(two_rank),
        .init_dly(init_dly), .rd_req(rd_req), .rd_rank(rd_rank), .rd_sel(rd_sel),
        .rd_valid(rd_valid), .rd_beat(rd_beat), .dly_out(dly_out), .done(done),
        .lane_fail(lane_fail), .err(err), .max_dly(max_dly)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic bit inwin(int d, int lo, int hi);
        return (d >= lo) && (d <= hi);
    endfunction

    // reference sweep built from R3..R7
    task automatic model(input bit two);
        int cur[L], cand[L];
        bit tog[L], prv[L];
        bit allt;
        for (int l = 0; l < L; l++) begin
            cur[l] = ini[l]; cand[l] = ini[l]; tog[l] = 0; prv[l] = 0; exp_tr[l] = 0;
        end
        exp_it = 0;
        for (int it = 0; it < 128; it++) begin
            allt = 1;
            for (int l = 0; l < L; l++) if (!exp_tr[l]) allt = 0;
            if (allt) break;
            exp_it++;
            for (int l = 0; l < L; l++) begin
                bit p;
                if (exp_tr[l]) continue;
                p = inwin(cur[l], lo0[l], hi0[l]);
                if (two) p = p && inwin(cur[l], lo1[l], hi1[l]);
                if (p && !prv[l]) begin cand[l] = cur[l]; tog[l] = 0; end
                if (!p) cur[l] = (cur[l] + 4) % 512;
                else if (((cur[l] - cand[l]) & 511) >= 40) begin
                    exp_tr[l] = 1; cur[l] = (cand[l] + 28) % 512;
                end else if (!tog[l]) begin cur[l] = (cur[l] + 1) % 512; tog[l] = 1; end
                else begin cur[l] = (cur[l] + 8) % 512; tog[l] = 0; end
                prv[l] = p;
            end
        end
        for (int l = 0; l < L; l++) exp_dly[l] = cur[l];
    endtask

    task automatic run_case(input string name, input bit two, input bit poke);
        int nreads = 0, cyc = 0, wait_c = -1, bad_order = 0, bad_hold = 0, nr;
        bit seen_done = 0;
        logic [L-1:0] ef;
        int emax = 0;
        nr = two ? 4 : 2;
        model(two);
        @(negedge clk);
        two_rank = two;
        for (int l = 0; l < L; l++) init_dly[l*W +: W] = W'(ini[l]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int l = 0; l < L; l++)
            chk(dly_out[l*W +: W] == W'(ini[l]), "R1", {name, " load"}, dly_out[l*W +: W], ini[l]);
        forever begin
            @(negedge clk);
            cyc++;
            if (rd_valid) begin rd_valid = 1'b0; nreads++; end
            if (poke && cyc == 40) start = 1'b1;
            else start = 1'b0;
            if (done) begin seen_done = 1; break; end
            if (cyc > 20000) break;
            if (wait_c >= 0 && !rd_req) bad_hold++;
            if (rd_req) begin
                if (wait_c < 0) wait_c = $urandom % 3;
                if (wait_c == 0) begin
                    int pos, it;
                    bit es, er;
                    pos = nreads % nr; it = nreads / nr;
                    er = pos[1]; es = pos[0] ^ it[0];
                    if (rd_rank != er || rd_sel != es) bad_order++;
                    for (int l = 0; l < L; l++) begin
                        int d;
                        bit p;
                        logic [7:0] eb;
                        d = int'(dly_out[l*W +: W]);
                        p = rd_rank ? inwin(d, lo1[l], hi1[l]) : inwin(d, lo0[l], hi0[l]);
                        eb = rd_sel ? 8'hAA : 8'h55;
                        rd_beat[l*8 +: 8] = p ? eb : eb ^ 8'(($urandom % 255) + 1);
                    end
                    rd_valid = 1'b1;
                    wait_c = -1;
                end else wait_c--;
            end
        end
        start = 1'b0;
        chk(seen_done, "R7", {name, " done seen (watchdog)"}, seen_done, 1);
        if (seen_done) begin
            ef = '0;
            for (int l = 0; l < L; l++) begin
                ef[l] = !exp_tr[l];
                if (exp_dly[l] > emax) emax = exp_dly[l];
                chk(dly_out[l*W +: W] == W'(exp_dly[l]), "R6", {name, " final delay"},
                    dly_out[l*W +: W], exp_dly[l]);
            end
            chk(lane_fail == ef, "R8", {name, " lane_fail"}, lane_fail, ef);
            chk(err == (ef != '0), "R8", {name, " err"}, err, ef != '0);
            chk(max_dly == W'(emax), "R8", {name, " max_dly"}, max_dly, emax);
            chk(nreads == exp_it * nr, "R7", {name, " read count"}, nreads, exp_it * nr);
            chk(bad_order == 0, "R2", {name, " read order"}, bad_order, 0);
            chk(bad_hold == 0, "R10", {name, " request held"}, bad_hold, 0);
            if (poke) chk(nreads == exp_it * nr, "R9", {name, " start while busy"}, nreads, exp_it * nr);
            @(negedge clk);
            chk(done == 1'b0, "R7", {name, " done one cycle"}, done, 0);
        end
    endtask

    task automatic set_all(int lo_a, int hi_a, int lo_b, int hi_b, int i0, int istep);
        for (int l = 0; l < L; l++) begin
            lo0[l] = lo_a; hi0[l] = hi_a; lo1[l] = lo_b; hi1[l] = hi_b;
            ini[l] = i0 + l * istep;
        end
    endtask

    initial begin
        #(4 * 195000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        chk(rd_req == 0 && done == 0 && lane_fail == 0 && err == 0 && max_dly == 0 && dly_out == 0,
            "R1", "reset state", {rd_req, done, err, lane_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5: one rank, common window
        set_all(64, 192, 0, 511, 16, 5);
        run_case("single_rank", 0, 0);
        // R3: both ranks, intersection governs
        set_all(48, 176, 80, 208, 10, 7);
        run_case("dual_rank", 1, 0);
        // R5: first iteration already inside the window
        set_all(32, 320, 0, 511, 96, 0);
        run_case("first_pass", 0, 0);
        // R8 R7: lane 3 never passes, lane 5 window too narrow
        set_all(64, 192, 0, 511, 20, 3);
        lo0[3] = 1; hi0[3] = 0;
        lo0[5] = 100; hi0[5] = 130;
        run_case("bad_lanes", 0, 0);
        // R9: start pulse mid sweep
        set_all(40, 200, 60, 220, 30, 4);
        run_case("poke_start", 1, 1);

        for (int k = 0; k < 10; k++) begin
            bit two;
            two = $urandom % 2;
            for (int l = 0; l < L; l++) begin
                lo0[l] = $urandom % 200;
                hi0[l] = lo0[l] + 24 + ($urandom % 120);
                lo1[l] = lo0[l] + int'($urandom % 33) - 16;
                hi1[l] = hi0[l] + int'($urandom % 33) - 16;
                ini[l] = $urandom % 180;
            end
            run_case($sformatf("random_%0d", k), two, 0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule